// File: doc/BRIEF.md
# NAND Flash Byte-Cycle Host Front-End

This block sits between a processor's register bus and an 8-bit NAND flash device. Software drives the device one byte at a time. It writes command bytes, address bytes and data bytes to three separate registers. Each write becomes one write-strobe cycle on the device pins, with the command-latch or address-latch line raised as the register requires. To read a byte, software first writes any value to a request register. The block then runs one read-strobe cycle, captures the returned byte into a read register and sets a sticky ready flag that software polls.

Command, address, data and read-request entries all enter one four-entry write buffer and leave it in arrival order. A read therefore never overtakes a write that was queued before it. The buffer's full, empty and overflow conditions are visible to software. There is no back-pressure on the register bus: every access completes in one clock. Software reads the full flag before each buffered write, and a buffered write made while the buffer is full is discarded and flagged. Inside the block, the buffer hands entries to the strobe engine over a valid/ready pair. An entry stays at the head of the buffer until the engine is idle or in its recovery clock.

The strobe widths are programmable in clocks. The device's ready/busy pin is synchronised, reported as a status bit, and its rising edge is latched as an interrupt event.

Top module: `nfc_host_if`

## Requirements
- R1: The control register (offset 0) holds bits [3:0] as the write-strobe delay, bits [7:4] as the read-strobe delay, bit 8 as the bus-width select and bit 9 as the page-size select (set means 512 bytes). It reads back exactly these ten bits, reads higher bits as 0, and resets to 0.
- R2: A write to offset 3 produces a write-strobe cycle with CLE high and ALE low. A write to offset 4 produces one with ALE high and CLE low. A write to offset 5 produces one with both low. In each case the data bus carries the written low byte with its output enable high.
- R3: A write strobe is held low for exactly (write delay + 1) clocks and a read strobe for exactly (read delay + 1) clocks. The delay used is the one in force when the entry leaves the buffer. Both strobes are high for at least one clock between cycles, and they are never low together.
- R4: All buffered entries reach the pins in the order they were written, so a read request runs only after every earlier command, address and data write has completed.
- R5: The buffer holds 4 entries. Status (offset 1) bit 1 is set while 4 entries are held, and bit 4 is set while none are held.
- R6: A write to offset 3, 4, 5 or 6 while the buffer is full is discarded and never reaches the pins, and it sets interrupt-status (offset 2) bit 1.
- R7: A write of any value to offset 6 queues one read strobe. The data bus is sampled on the last low clock of that strobe into the read register (offset 7), and interrupt bit 3 is set at the same edge. Status bit 3 is set from request acceptance until capture, and output enable stays low during the read.
- R8: Interrupt-status bits are sticky. Writing 1 to a bit clears it, and writing 0 leaves it. An event in the same clock as its clear wins.
- R9: The ready/busy pin passes through two flops to status bit 0. A rising edge of that synchronised level sets interrupt bit 0.
- R10: Status bit 2 is set while any command, address or data entry is queued or on the pins. Interrupt bit 4 is set when the last such pending write completes. Interrupt bit 2 is set when the buffer leaves the full state.
- R11: After reset, status reads 0x10 with the ready/busy pin low, interrupt status reads 0, both strobes are high, and CLE, ALE and output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one clock per access |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr, no read side effects |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the device |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data returned by the device |
| nand_rb | input | 1 | Device ready/busy, high when ready |

## Verification
The hardest state to reach from the ports is a full buffer, and a write that arrives while the engine still holds an entry. A software-style stream that polls the full flag never creates it. A directed run therefore sets both delays to their maximum and issues six buffered writes on consecutive clocks. The engine takes the first entry, the buffer fills, and the sixth write is dropped. The bench then confirms that only five strobe cycles appear and that the overflow and leave-full events are latched. Seeded random traffic with varied delays then checks every strobe's kind, byte and width against a queue of expected cycles, and checks read data against a device model.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  localparam int BYTE_W = 8;
  localparam int IRQ_W  = 5;
  localparam int STAT_W = 5;

  // register offsets; the bench and software decode these
  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_STATUS = 3'd1;
  localparam logic [2:0] RA_IRQ    = 3'd2;
  localparam logic [2:0] RA_CMD    = 3'd3;
  localparam logic [2:0] RA_ADDR   = 3'd4;
  localparam logic [2:0] RA_WDATA  = 3'd5;
  localparam logic [2:0] RA_RDREQ  = 3'd6;
  localparam logic [2:0] RA_RDATA  = 3'd7;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDREQ = 2'd3
  } nfc_op_e;

  typedef struct packed {
    nfc_op_e           op;
    logic [BYTE_W-1:0] data;
  } nfc_entry_t;

endpackage

// File: rtl/nfc_wbuf.sv
module nfc_wbuf
  import nfc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  nfc_entry_t in_entry,
  output logic       out_valid,
  input  logic       out_ready,
  output nfc_entry_t out_entry,
  output logic       full,
  output logic       empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  nfc_entry_t        mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              push, pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_entry = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_WBUF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5

  AST_WBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_entry))); // R4

  AST_WBUF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !out_ready) |=> full); // R6

endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe
  import nfc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  nfc_entry_t        in_entry,
  input  logic [DLY_W-1:0]  wr_dly,
  input  logic [DLY_W-1:0]  rd_dly,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [BYTE_W-1:0] dq_in,
  output logic              done,
  output logic              done_rd,
  output logic [BYTE_W-1:0] rd_byte
);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} eng_state_e;

  eng_state_e       state;
  nfc_entry_t       cur;
  logic [DLY_W-1:0] cnt;
  logic             is_rd, active;

  assign is_rd    = (cur.op == OP_RDREQ);
  assign active   = (state != S_IDLE);
  assign in_ready = (state != S_LOW);

  assign we_n   = !(state == S_LOW && !is_rd);
  assign re_n   = !(state == S_LOW && is_rd);
  assign cle    = active && (cur.op == OP_CMD);
  assign ale    = active && (cur.op == OP_ADDR);
  assign dq_oe  = active && !is_rd;
  assign dq_out = cur.data;

  assign done    = (state == S_LOW) && (cnt == '0);
  assign done_rd = is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      cnt     <= '0;
      rd_byte <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_HIGH: begin
          if (in_valid) begin
            cur   <= in_entry;
            cnt   <= (in_entry.op == OP_RDREQ) ? rd_dly : wr_dly;
            state <= S_LOW;
          end else begin
            state <= S_IDLE;
          end
        end
        S_LOW: begin
          if (cnt == '0) begin
            state <= S_HIGH;
            if (is_rd) rd_byte <= dq_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~we_n, ~re_n})); // R3

  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale)); // R2

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) || $fell(re_n)) |-> $past(we_n && re_n)); // R3

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe); // R7

endmodule

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign level = chain[STAGES-1];
  assign rise  = level && !prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R9

endmodule

// File: rtl/nfc_host_if.sv
module nfc_host_if
  import nfc_pkg::*;
#(
  parameter int WBUF_DEPTH = 4,
  parameter int RB_STAGES  = 2,
  parameter int DLY_W      = 4,
  parameter int ADDR_W     = 3,
  parameter int REG_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rb
);

  localparam int CTRL_W = 2 * DLY_W + 2;
  localparam int PEND_W = $clog2(WBUF_DEPTH + 2);

  // control register
  logic [CTRL_W-1:0] ctrl_q;
  logic [DLY_W-1:0]  wr_dly, rd_dly;

  assign wr_dly = ctrl_q[DLY_W-1:0];
  assign rd_dly = ctrl_q[2*DLY_W-1:DLY_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(RA_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  // buffered-write decode
  logic       q_hit;
  nfc_op_e    q_op;
  nfc_entry_t q_entry;

  always_comb begin
    q_hit = 1'b0;
    q_op  = OP_CMD;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(RA_CMD))   begin q_hit = 1'b1; q_op = OP_CMD;   end
      if (bus_addr == ADDR_W'(RA_ADDR))  begin q_hit = 1'b1; q_op = OP_ADDR;  end
      if (bus_addr == ADDR_W'(RA_WDATA)) begin q_hit = 1'b1; q_op = OP_WDATA; end
      if (bus_addr == ADDR_W'(RA_RDREQ)) begin q_hit = 1'b1; q_op = OP_RDREQ; end
    end
  end

  assign q_entry.op   = q_op;
  assign q_entry.data = bus_wdata[BYTE_W-1:0];

  // buffer and strobe engine
  logic       buf_in_ready, buf_full, buf_empty, eng_valid, eng_ready;
  nfc_entry_t eng_entry;
  logic       eng_done, eng_done_rd;
  logic [BYTE_W-1:0] rd_byte;

  nfc_wbuf #(.DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (q_hit),
    .in_ready  (buf_in_ready),
    .in_entry  (q_entry),
    .out_valid (eng_valid),
    .out_ready (eng_ready),
    .out_entry (eng_entry),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  nfc_strobe #(.DLY_W(DLY_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (eng_valid),
    .in_ready (eng_ready),
    .in_entry (eng_entry),
    .wr_dly   (wr_dly),
    .rd_dly   (rd_dly),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe),
    .dq_in    (nand_dq_in),
    .done     (eng_done),
    .done_rd  (eng_done_rd),
    .rd_byte  (rd_byte)
  );

  logic rb_level, rb_rise;

  nfc_rb_sync #(.STAGES(RB_STAGES)) u_rb_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (nand_rb),
    .level (rb_level),
    .rise  (rb_rise)
  );

  // pending accounting: queued plus in-flight entries by kind
  logic              acc_push, wr_push, rd_push, wr_fin, rd_fin, drop;
  logic [PEND_W-1:0] wr_pend, rd_pend, wr_pend_d, rd_pend_d;

  assign acc_push = q_hit && buf_in_ready;
  assign drop     = q_hit && !buf_in_ready;
  assign wr_push  = acc_push && (q_op != OP_RDREQ);
  assign rd_push  = acc_push && (q_op == OP_RDREQ);
  assign wr_fin   = eng_done && !eng_done_rd;
  assign rd_fin   = eng_done && eng_done_rd;

  assign wr_pend_d = wr_pend + PEND_W'(wr_push) - PEND_W'(wr_fin);
  assign rd_pend_d = rd_pend + PEND_W'(rd_push) - PEND_W'(rd_fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pend <= '0;
      rd_pend <= '0;
    end else begin
      wr_pend <= wr_pend_d;
      rd_pend <= rd_pend_d;
    end
  end

  // sticky interrupt status
  logic             full_prev;
  logic [IRQ_W-1:0] irq_q, irq_set, irq_w1c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_prev <= 1'b0;
    else        full_prev <= buf_full;
  end

  assign irq_set[0] = rb_rise;
  assign irq_set[1] = drop;
  assign irq_set[2] = full_prev && !buf_full;
  assign irq_set[3] = rd_fin;
  assign irq_set[4] = (wr_pend != '0) && (wr_pend_d == '0);

  assign irq_w1c = (bus_we && bus_addr == ADDR_W'(RA_IRQ)) ? bus_wdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= (irq_q & ~irq_w1c) | irq_set;
  end

  // status and readback
  logic [STAT_W-1:0] status;

  assign status = {buf_empty, (rd_pend != '0), (wr_pend != '0), buf_full, rb_level};

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(RA_CTRL))   bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (bus_addr == ADDR_W'(RA_STATUS)) bus_rdata[STAT_W-1:0] = status;
    if (bus_addr == ADDR_W'(RA_IRQ))    bus_rdata[IRQ_W-1:0]  = irq_q;
    if (bus_addr == ADDR_W'(RA_RDATA))  bus_rdata[BYTE_W-1:0] = rd_byte;
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irq_q) & ~$past(irq_w1c)) & ~irq_q) == '0)); // R8

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wr_pend) + 32'(rd_pend)) <= (WBUF_DEPTH + 1)); // R10

  AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty)); // R5

  AST_RDREADY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fin |=> irq_q[3]); // R7

  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> irq_q[1]); // R6

endmodule

// File: tb/nfc_host_if_bench.sv
`timescale 1ns/1ps
module nfc_host_if_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in;
  logic        nand_rb = 1'b0;

  always #2.5 clk = ~clk;

  nfc_host_if u_nfc_host_if (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    int         op;
    logic [7:0] data;
    int         len;
  } exp_t;

  exp_t exp_q[$];
  int   cur_wr = 0, cur_rd = 0;
  int   rd_issued = 0;

  function automatic logic [7:0] dev_byte(input int k);
    return 8'((k * 29) + 8'h3C);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // pin monitor and device model, sampled on the falling clock edge
  logic prev_we = 1'b1, prev_re = 1'b1;
  int   low_cnt = 0, want_len = 0, dev_k = 0;
  initial nand_dq_in = dev_byte(0);

  always @(negedge clk) begin
    if (rst_n) begin
      if ((!nand_we_n && prev_we) || (!nand_re_n && prev_re)) begin
        int obs;
        obs = !nand_re_n ? 3 : nand_cle ? 0 : nand_ale ? 1 : 2;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected strobe", obs, 32'hFF);
          want_len = 0;
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(obs == e.op, "R4 cycle kind/order", obs, e.op);
          if (e.op != 3) begin
            check(nand_dq_out == e.data, "R2 write byte", nand_dq_out, e.data);
            check(nand_dq_oe == 1'b1, "R2 output enable", nand_dq_oe, 1);
          end else begin
            check(nand_dq_oe == 1'b0, "R7 no drive on read", nand_dq_oe, 0);
          end
          want_len = e.len;
        end
        low_cnt = 1;
      end else if (!nand_we_n || !nand_re_n) begin
        low_cnt++;
      end
      if ((nand_we_n && !prev_we) || (nand_re_n && !prev_re)) begin
        check(low_cnt == want_len, "R3 strobe low width", low_cnt, want_len);
        if (nand_re_n && !prev_re) begin
          dev_k++;
          nand_dq_in = dev_byte(dev_k);
        end
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      check(1'b0, "R4 watchdog expired", cyc, 150000);
      summary();
      $finish;
    end
  end

  // bus tasks; each is entered and left on a falling edge
  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic set_ctrl(input int wr, input int rd);
    bus_write(3'd0, 16'((rd << 4) | wr));
    cur_wr = wr; cur_rd = rd;
  endtask

  task automatic queue_op(input int op, input logic [7:0] d);
    exp_t e;
    e.op = op; e.data = d;
    e.len = (op == 3) ? cur_rd + 1 : cur_wr + 1;
    exp_q.push_back(e);
    bus_write(3'(3 + op), {8'h00, d});
  endtask

  task automatic wait_drain();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(3'd1, s);
      if (s[4] && !s[3] && !s[2]) break;
    end
    @(negedge clk);
  endtask

  task automatic fetch_read(input string req);
    logic [15:0] v;
    for (int i = 0; i < 400; i++) begin
      bus_read(3'd2, v);
      if (v[3]) break;
    end
    check(v[3] == 1'b1, req, v, 16'h8);
    bus_read(3'd7, v);
    check(v == {8'h00, dev_byte(rd_issued)}, req, v, {8'h00, dev_byte(rd_issued)});
    rd_issued++;
    bus_write(3'd2, 16'h0008);
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    bus_read(3'd1, v); check(v == 16'h0010, "R11 status after reset", v, 16'h10);
    bus_read(3'd2, v); check(v == 16'h0000, "R11 irq after reset", v, 0);
    check({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe} == 5'b11000,
          "R11 pins after reset", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    bus_read(3'd0, v); check(v == 16'h0000, "R1 ctrl after reset", v, 0);

    // R1 readback
    bus_write(3'd0, 16'hFFFF);
    bus_read(3'd0, v); check(v == 16'h03FF, "R1 ctrl readback", v, 16'h3FF);
    bus_write(3'd0, 16'h0296);
    bus_read(3'd0, v); check(v == 16'h0296, "R1 ctrl fields", v, 16'h296);

    // R10 / R7 pending bits with long strobes
    set_ctrl(15, 15);
    queue_op(0, 8'h90);
    bus_read(3'd1, v); check(v[2] == 1'b1, "R10 write pending bit", v, 16'h4);
    queue_op(3, 8'h00);
    bus_read(3'd1, v); check(v[3] == 1'b1, "R7 read pending bit", v, 16'h8);
    wait_drain();
    bus_read(3'd2, v); check(v[4] == 1'b1, "R10 write-done irq", v, 16'h10);
    fetch_read("R7 read capture");
    bus_write(3'd2, 16'h001F);

    // R5 / R6 / R10 overflow: six writes on consecutive clocks
    for (int i = 0; i < 5; i++) queue_op(2, 8'(8'hA0 + i));
    bus_write(3'd5, 16'h00A5);
    bus_read(3'd1, v); check(v[1] == 1'b1 && v[4] == 1'b0, "R5 full flag", v, 16'h2);
    bus_read(3'd2, v); check(v[1] == 1'b1, "R6 overflow irq", v, 16'h2);
    wait_drain();
    bus_read(3'd2, v); check(v[2] == 1'b1, "R10 leave-full irq", v, 16'h4);
    check(exp_q.size() == 0, "R6 dropped entry absent", exp_q.size(), 0);
    bus_read(3'd1, v); check(v[4:1] == 4'b1000, "R5 empty after drain", v, 16'h10);
    bus_write(3'd2, 16'h001F);

    // R9 / R8 ready-busy synchroniser and write-1-to-clear
    nand_rb = 1'b1;
    @(negedge clk);
    bus_read(3'd1, v); check(v[0] == 1'b0, "R9 two-flop latency", v, 0);
    bus_read(3'd1, v); check(v[0] == 1'b1, "R9 level after sync", v, 1);
    bus_read(3'd2, v); check(v[0] == 1'b1, "R9 rise irq", v, 1);
    bus_write(3'd2, 16'h001E);
    bus_read(3'd2, v); check(v[0] == 1'b1, "R8 write zero keeps bit", v, 1);
    bus_write(3'd2, 16'h0001);
    bus_read(3'd2, v); check(v[0] == 1'b0, "R8 write one clears bit", v, 0);

    // R4 directed ordering: read behind three writes
    set_ctrl(1, 2);
    queue_op(0, 8'h00);
    queue_op(1, 8'h12);
    queue_op(2, 8'h5A);
    queue_op(3, 8'h00);
    fetch_read("R4 read after writes");
    wait_drain();

    // seeded random traffic, software-style polling of the full flag
    for (int it = 0; it < 300; it++) begin
      int op;
      if (it % 25 == 0) begin
        wait_drain();
        set_ctrl(($urandom % 8 == 0) ? 15 : int'($urandom % 4),
                 ($urandom % 8 == 0) ? 15 : int'($urandom % 4));
      end
      for (int p = 0; p < 200; p++) begin
        bus_read(3'd1, v);
        if (!v[1]) break;
      end
      op = int'($urandom % 4);
      queue_op(op, 8'($urandom));
      if (op == 3) fetch_read("R7 random read data");
    end
    wait_drain();
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4 all queued cycles seen", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule